// File: doc/BRIEF.md
# Compare-Reload Timer with Toggle Output

This block is one 16-bit up-counting timer channel. Once started, it advances by one on every count tick. A tick that finds the counter equal to the active compare value is a match. In count-until-compare mode, a match sends the counter back to a programmable start value, so the block produces a periodic event.

Each match raises a one-cycle pulse on `cmp_pulse`, which downstream trigger logic can use directly. When the output mode is set to toggle, each match also flips the `tmr_out` pin, which turns the match stream into a square wave. The active compare value can be refreshed from a preload register at each match. Software can therefore change the period at any time without producing a short or long cycle.

Software reaches the channel through a word-wide write port and a combinational read port. Counting starts only when all three conditions hold: a nonzero count mode is written, the channel enable bit is set, and the direction bit is up.

Top module: `cmp_reload_timer`

## Requirements
- R1: After a clock edge with `rst_n` low, every register reads 0 and `tmr_out` and `cmp_pulse` are 0.
- R2: While running, the counter rises by one on each clock edge with `cnt_tick` high and holds on edges without it. The value wraps from 0xFFFF to 0.
- R3: A tick that finds the counter equal to the active compare value is a match. With mode-register bit 4 (repeat-length) set, a match reloads the counter from the start-value register (address 1). With bit 4 clear, the counter steps past the compare value.
- R4: `cmp_pulse` is high for exactly the cycle after each matching tick.
- R5: When mode-register bits 10:8 equal 3, `tmr_out` inverts after each match. Any other output code leaves `tmr_out` unchanged.
- R6: When bits 1:0 of the compare-control register (address 5) equal 1, a match copies the preload register (address 4) into the active compare register (address 3). Other codes leave the compare register unchanged.
- R7: With mode-register bit 3 (single-shot) set, the first match stops the channel. The channel stays stopped until the mode register is written again.
- R8: The channel counts only when all of these hold: bit 0 of the enable register (address 6) is 1, mode-register bits 2:0 are nonzero, and bit 5 (down) is 0. Otherwise the counter holds.
- R9: A write lands at the next clock edge. A write to the counter (address 2) or to the compare register (address 3) wins over counting or reloading in the same cycle. The read port returns the addressed register combinationally. The mode register is at address 0 and reads back bits 10:8 and 5:0.
- R10: When both the start value and the compare value are 0, every running tick is a match, so a toggling output changes on every tick.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register write address |
| wr_data | input | 16 | Register write data |
| rd_addr | input | 3 | Register read address |
| rd_data | output | 16 | Read data for `rd_addr` |
| cnt_tick | input | 1 | Primary count source, one pulse per count |
| tmr_out | output | 1 | Toggle output |
| cmp_pulse | output | 1 | One-cycle pulse per match |

## Verification
The assertions assume that `cnt_tick` and the write port are synchronous to `clk` and are never unknown out of reset. They also assume that software writes a start value no greater than the compare value whenever repeat-length mode is in use. The stimulus drives every input on the falling clock edge from one process, so it never changes an input near the active edge. The random phase draws preload values only from a range at or above the start value.

// File: rtl/crt_pkg.sv
// Shared definitions for the compare-reload timer: register addresses,
// mode-register field layout and the decoded mode structure.
// Assumes the data word is at least 11 bits wide.
package crt_pkg;
    localparam int AW = 3;
    localparam int CL_W = 2;

    localparam logic [AW-1:0] ADR_MODE   = 3'd0;
    localparam logic [AW-1:0] ADR_START  = 3'd1;
    localparam logic [AW-1:0] ADR_COUNT  = 3'd2;
    localparam logic [AW-1:0] ADR_CMP    = 3'd3;
    localparam logic [AW-1:0] ADR_PRE    = 3'd4;
    localparam logic [AW-1:0] ADR_CMPCTL = 3'd5;
    localparam logic [AW-1:0] ADR_ENABLE = 3'd6;

    localparam int F_SRC  = 0;   // 3-bit count source, 0 = idle
    localparam int F_ONCE = 3;
    localparam int F_LEN  = 4;
    localparam int F_DOWN = 5;
    localparam int F_OUT  = 8;   // 3-bit output mode

    localparam logic [2:0]      OUT_TOGGLE  = 3'd3;
    localparam logic [CL_W-1:0] CL_ON_MATCH = 2'd1;

    typedef struct packed {
        logic [2:0] src;
        logic       once;
        logic       len;
        logic       down;
        logic [2:0] omode;
    } mode_t;
endpackage

// File: rtl/crt_regs.sv
// Register file of the timer: mode, start value, preload, compare control
// and enable. Decodes the write port into strobes for the registers kept
// in the counting core, and serves the combinational read port.
// Assumes W >= 11 so every mode field fits in the data word.
module crt_regs
    import crt_pkg::*;
#(
    parameter int W = 16
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            wr_en,
    input  logic [AW-1:0]   wr_addr,
    input  logic [W-1:0]    wr_data,
    input  logic [AW-1:0]   rd_addr,
    input  logic [W-1:0]    count,
    input  logic [W-1:0]    cmp,
    output logic [W-1:0]    rd_data,
    output mode_t           mode,
    output logic [W-1:0]    start_val,
    output logic [W-1:0]    pre_val,
    output logic [CL_W-1:0] cmpctl,
    output logic            chan_en,
    output logic            mode_wr,
    output logic            cnt_wr,
    output logic            cmp_wr
);
    // Write strobes for each addressed register.
    assign mode_wr = wr_en && (wr_addr == ADR_MODE);
    assign cnt_wr  = wr_en && (wr_addr == ADR_COUNT);
    assign cmp_wr  = wr_en && (wr_addr == ADR_CMP);

    // Capture the mode fields on a mode write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode <= '0;
        end else if (mode_wr) begin
            mode.src   <= wr_data[F_SRC +: 3];
            mode.once  <= wr_data[F_ONCE];
            mode.len   <= wr_data[F_LEN];
            mode.down  <= wr_data[F_DOWN];
            mode.omode <= wr_data[F_OUT +: 3];
        end
    end

    // Capture the plain data registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            start_val <= '0;
            pre_val   <= '0;
            cmpctl    <= '0;
            chan_en   <= 1'b0;
        end else if (wr_en) begin
            if (wr_addr == ADR_START)  start_val <= wr_data;
            if (wr_addr == ADR_PRE)    pre_val   <= wr_data;
            if (wr_addr == ADR_CMPCTL) cmpctl    <= wr_data[CL_W-1:0];
            if (wr_addr == ADR_ENABLE) chan_en   <= wr_data[0];
        end
    end

    // Read multiplexer.
    always_comb begin
        rd_data = '0;
        case (rd_addr)
            ADR_MODE: begin
                rd_data[F_SRC +: 3] = mode.src;
                rd_data[F_ONCE]     = mode.once;
                rd_data[F_LEN]      = mode.len;
                rd_data[F_DOWN]     = mode.down;
                rd_data[F_OUT +: 3] = mode.omode;
            end
            ADR_START:  rd_data = start_val;
            ADR_COUNT:  rd_data = count;
            ADR_CMP:    rd_data = cmp;
            ADR_PRE:    rd_data = pre_val;
            ADR_CMPCTL: rd_data[CL_W-1:0] = cmpctl;
            ADR_ENABLE: rd_data[0] = chan_en;
            default:    rd_data = '0;
        endcase
    end
endmodule

// File: rtl/crt_core.sv
// Counting core: holds the counter, the active compare register and the
// single-shot stop flag. It detects matches and applies start-value reload
// and compare preload. Only up counting exists; the down bit idles the core.
// Assumes start value <= compare value when repeat-length mode is used.
module crt_core
    import crt_pkg::*;
#(
    parameter int W = 16
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            tick,
    input  mode_t           mode,
    input  logic [W-1:0]    start_val,
    input  logic [W-1:0]    pre_val,
    input  logic [CL_W-1:0] cmpctl,
    input  logic            chan_en,
    input  logic            mode_wr,
    input  logic            cnt_wr,
    input  logic            cmp_wr,
    input  logic [W-1:0]    wr_data,
    output logic [W-1:0]    count,
    output logic [W-1:0]    cmp,
    output logic            match
);
    logic stopped;
    logic running;
    logic step;

    // The channel runs only when enabled, sourced, counting up and not stopped.
    assign running = chan_en && (mode.src != 3'd0) && !mode.down && !stopped;
    assign step    = tick && running;
    assign match   = step && (count == cmp);

    // Counter: a software write wins, then reload on match, then increment.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count <= '0;
        end else if (cnt_wr) begin
            count <= wr_data;
        end else if (match && mode.len) begin
            count <= start_val;
        end else if (step) begin
            count <= count + 1'b1;
        end
    end

    // Active compare register: a software write wins over the preload copy.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cmp <= '0;
        end else if (cmp_wr) begin
            cmp <= wr_data;
        end else if (match && (cmpctl == CL_ON_MATCH)) begin
            cmp <= pre_val;
        end
    end

    // Single-shot stop flag, cleared by any mode write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stopped <= 1'b0;
        end else if (mode_wr) begin
            stopped <= 1'b0;
        end else if (match && mode.once) begin
            stopped <= 1'b1;
        end
    end

    // R2
    hold_no_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick && !cnt_wr) |=> $stable(count));
    // R3
    reinit_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (match && mode.len && !cnt_wr) |=> (count == $past(start_val)));
    // R6
    preload_copy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (match && (cmpctl == CL_ON_MATCH) && !cmp_wr) |=> (cmp == $past(pre_val)));
    // R7
    stop_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (stopped && !mode_wr && !cnt_wr) |=> $stable(count));
    // R8
    idle_no_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!chan_en || mode.down || (mode.src == 3'd0)) |-> !match);
endmodule

// File: rtl/crt_outgen.sv
// Output stage: registers the one-cycle match pulse and the toggle flop.
// Assumes match is a single-cycle event qualified by the core.
module crt_outgen
    import crt_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       match,
    input  logic [2:0] omode,
    output logic       tmr_out,
    output logic       cmp_pulse
);
    // Register the match as a one-cycle pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) cmp_pulse <= 1'b0;
        else        cmp_pulse <= match;
    end

    // Flip the output on each match when the toggle mode is selected.
    always_ff @(posedge clk) begin
        if (!rst_n)                             tmr_out <= 1'b0;
        else if (match && (omode == OUT_TOGGLE)) tmr_out <= ~tmr_out;
    end

    // R4
    pulse_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        match |=> cmp_pulse);
    // R5
    toggle_on_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (match && (omode == OUT_TOGGLE)) |=> (tmr_out != $past(tmr_out)));
    // R5
    out_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!match || (omode != OUT_TOGGLE)) |=> $stable(tmr_out));
endmodule

// File: rtl/cmp_reload_timer.sv
// Top of the compare-reload timer channel: ties the register file, the
// counting core and the output stage together.
// Assumes cnt_tick is synchronous to clk and W >= 11.
module cmp_reload_timer
    import crt_pkg::*;
#(
    parameter int W = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_addr,
    input  logic [W-1:0]  wr_data,
    input  logic [AW-1:0] rd_addr,
    output logic [W-1:0]  rd_data,
    input  logic          cnt_tick,
    output logic          tmr_out,
    output logic          cmp_pulse
);
    mode_t           mode;
    logic [W-1:0]    start_val;
    logic [W-1:0]    pre_val;
    logic [CL_W-1:0] cmpctl;
    logic            chan_en;
    logic            mode_wr;
    logic            cnt_wr;
    logic            cmp_wr;
    logic [W-1:0]    count;
    logic [W-1:0]    cmp;
    logic            match;

    crt_regs #(.W(W)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_addr(rd_addr), .count(count), .cmp(cmp),
        .rd_data(rd_data), .mode(mode), .start_val(start_val),
        .pre_val(pre_val), .cmpctl(cmpctl), .chan_en(chan_en),
        .mode_wr(mode_wr), .cnt_wr(cnt_wr), .cmp_wr(cmp_wr)
    );

    crt_core #(.W(W)) u_core (
        .clk(clk), .rst_n(rst_n), .tick(cnt_tick), .mode(mode),
        .start_val(start_val), .pre_val(pre_val), .cmpctl(cmpctl),
        .chan_en(chan_en), .mode_wr(mode_wr), .cnt_wr(cnt_wr),
        .cmp_wr(cmp_wr), .wr_data(wr_data), .count(count), .cmp(cmp),
        .match(match)
    );

    crt_outgen u_out (
        .clk(clk), .rst_n(rst_n), .match(match), .omode(mode.omode),
        .tmr_out(tmr_out), .cmp_pulse(cmp_pulse)
    );
endmodule

// File: tb/cmp_reload_timer_tb.sv
`timescale 1ns/1ps
// Bench: behavioural reference model updated on every clock edge and
// compared 5 ns later; directed scenarios add named checks.
module cmp_reload_timer_tb;
    localparam int W = 16;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic wr_en = 1'b0;
    logic [2:0] wr_addr = '0;
    logic [W-1:0] wr_data = '0;
    logic [2:0] rd_addr = 3'd2;
    logic [W-1:0] rd_data;
    logic cnt_tick = 1'b0;
    logic tmr_out, cmp_pulse;

    int n_chk = 0;
    int n_bad = 0;
    int pulses = 0;

    always #10 clk = ~clk;

    cmp_reload_timer #(.W(W)) u_dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
        .cnt_tick(cnt_tick), .tmr_out(tmr_out), .cmp_pulse(cmp_pulse)
    );

    // Reference model state.
    logic [15:0] m_mode, m_start, m_cnt, m_cmp, m_pre;
    logic [1:0]  m_cc;
    logic        m_en, m_stop, m_out, m_pulse;

    function automatic logic [15:0] model_read(input logic [2:0] a);
        case (a)
            3'd0: return m_mode;
            3'd1: return m_start;
            3'd2: return m_cnt;
            3'd3: return m_cmp;
            3'd4: return m_pre;
            3'd5: return {14'd0, m_cc};
            3'd6: return {15'd0, m_en};
            default: return 16'd0;
        endcase
    endfunction

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // Model update at each edge, then comparison 5 ns later.
    always @(posedge clk) begin
        logic run, hit;
        logic [15:0] nc, ncmp;
        logic nstop, nout;
        if (!rst_n) begin
            m_mode = 0; m_start = 0; m_cnt = 0; m_cmp = 0; m_pre = 0;
            m_cc = 0; m_en = 0; m_stop = 0; m_out = 0; m_pulse = 0;
        end else begin
            run   = m_en && (m_mode[2:0] != 0) && !m_mode[5] && !m_stop;
            hit   = cnt_tick && run && (m_cnt == m_cmp);
            nc    = m_cnt; ncmp = m_cmp; nstop = m_stop; nout = m_out;
            if (hit) begin
                nc    = m_mode[4] ? m_start : m_cnt + 16'd1;
                if (m_cc == 2'd1) ncmp = m_pre;
                if (m_mode[3]) nstop = 1'b1;
                if (m_mode[10:8] == 3'd3) nout = ~m_out;
            end else if (cnt_tick && run) begin
                nc = m_cnt + 16'd1;
            end
            if (wr_en) begin
                case (wr_addr)
                    3'd0: begin m_mode = wr_data & 16'h073F; nstop = 1'b0; end
                    3'd1: m_start = wr_data;
                    3'd2: nc = wr_data;
                    3'd3: ncmp = wr_data;
                    3'd4: m_pre = wr_data;
                    3'd5: m_cc = wr_data[1:0];
                    3'd6: m_en = wr_data[0];
                    default: ;
                endcase
            end
            m_cnt = nc; m_cmp = ncmp; m_stop = nstop; m_out = nout; m_pulse = hit;
        end
        #5;
        check(tmr_out == m_out, "R5 per-cycle tmr_out", tmr_out, m_out);
        check(cmp_pulse == m_pulse, "R4 per-cycle cmp_pulse", cmp_pulse, m_pulse);
        check(rd_data == model_read(rd_addr), "R2/R3/R9 per-cycle rd_data",
              rd_data, model_read(rd_addr));
        if (cmp_pulse) pulses++;
    end

    task automatic wr(input logic [2:0] a, input logic [15:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            cnt_tick = 1'b1;
        end
        @(negedge clk);
        cnt_tick = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic rd(input logic [2:0] a, output logic [15:0] v);
        @(negedge clk);
        rd_addr = a;
        #1 v = rd_data;
    endtask

    initial begin : watchdog
        #(20 * 200000);
        n_chk++; n_bad++;
        $display("FAIL watchdog expired");
        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin : main
        logic [15:0] v;
        logic o0;
        int p0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        idle(1);
        // R1 reset state
        check(tmr_out == 0 && cmp_pulse == 0, "R1 outputs after reset", tmr_out, 0);
        for (int a = 0; a < 7; a++) begin
            rd(3'(a), v);
            check(v == 0, "R1 register after reset", v, 0);
        end
        rd_addr = 3'd2;

        // R8 enabled but count source zero: idle
        wr(3'd6, 16'd1);
        ticks(5);
        rd(3'd2, v); check(v == 0, "R8 idle with source 0", v, 0);

        // R3/R4/R5 period of five ticks
        wr(3'd1, 16'd0); wr(3'd3, 16'd4); wr(3'd4, 16'd4); wr(3'd5, 16'd1);
        wr(3'd0, 16'h0311);
        rd(3'd0, v); check(v == 16'h0311, "R9 mode readback", v, 16'h0311);
        rd_addr = 3'd2;
        pulses = 0;
        ticks(20); idle(2);
        check(pulses == 4, "R4 four pulses in 20 ticks", pulses, 4);
        rd(3'd2, v); check(v == 0, "R3 counter reloaded to start", v, 0);
        ticks(2);
        rd(3'd2, v); check(v == 2, "R2 counter after two ticks", v, 2);
        idle(5);
        rd(3'd2, v); check(v == 2, "R2 hold without ticks", v, 2);

        // R6 preload copied at match
        wr(3'd4, 16'd2);
        rd(3'd3, v); check(v == 4, "R6 compare unchanged before match", v, 4);
        ticks(3);
        rd(3'd3, v); check(v == 2, "R6 compare loaded from preload", v, 2);
        check(tmr_out == 1, "R5 output after five toggles", tmr_out, 1);

        // R6 other compare-control code keeps compare
        wr(3'd5, 16'd0); wr(3'd4, 16'd9);
        ticks(3);
        rd(3'd3, v); check(v == 2, "R6 no copy with code 0", v, 2);

        // R5 output mode 0 holds output but still pulses
        wr(3'd0, 16'h0011);
        o0 = tmr_out; p0 = pulses;
        ticks(3); idle(1);
        check(tmr_out == o0, "R5 hold with output mode 0", tmr_out, o0);
        check(pulses == p0 + 1, "R4 pulse with output mode 0", pulses, p0 + 1);

        // R7 single-shot
        wr(3'd0, 16'h0319);
        p0 = pulses;
        ticks(3); ticks(4); idle(1);
        rd(3'd2, v); check(v == 0, "R7 stopped after first match", v, 0);
        check(pulses == p0 + 1, "R7 single pulse", pulses, p0 + 1);
        wr(3'd0, 16'h0311);
        ticks(1);
        rd(3'd2, v); check(v == 1, "R7 restart after mode write", v, 1);

        // R8 enable off and down bit
        wr(3'd6, 16'd0);
        ticks(4);
        rd(3'd2, v); check(v == 1, "R8 hold with enable off", v, 1);
        wr(3'd6, 16'd1);
        wr(3'd0, 16'h0331);
        ticks(3);
        rd(3'd2, v); check(v == 1, "R8 hold with down bit", v, 1);
        wr(3'd0, 16'h0311);

        // R9 counter write, and write beating a tick
        wr(3'd2, 16'd0);
        ticks(1);
        rd(3'd2, v); check(v == 1, "R9 count after write", v, 1);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = 3'd2; wr_data = 16'd0; cnt_tick = 1'b1;
        @(negedge clk);
        wr_en = 1'b0; cnt_tick = 1'b0;
        rd(3'd2, v); check(v == 0, "R9 write wins over tick", v, 0);

        // R3 length bit clear: counter steps past compare
        wr(3'd0, 16'h0301);
        ticks(4);
        rd(3'd2, v); check(v == 4, "R3 pass compare without length", v, 4);

        // R10 zero start and compare: toggle every tick
        wr(3'd0, 16'h0311); wr(3'd2, 16'd0); wr(3'd1, 16'd0);
        wr(3'd3, 16'd0); wr(3'd4, 16'd0); wr(3'd5, 16'd1);
        o0 = tmr_out;
        ticks(1);
        check(tmr_out == ~o0, "R10 toggle on first tick", tmr_out, ~o0);
        ticks(1);
        check(tmr_out == o0, "R10 toggle on second tick", tmr_out, o0);
        p0 = pulses;
        ticks(6); idle(1);
        check(pulses == p0 + 6, "R10 pulse per tick", pulses, p0 + 6);

        // R3 nonzero start value
        wr(3'd1, 16'd10); wr(3'd3, 16'd12); wr(3'd4, 16'd12); wr(3'd2, 16'd10);
        ticks(3);
        rd(3'd2, v); check(v == 10, "R3 reload to nonzero start", v, 10);

        // Random phase: model compared every clock
        for (int i = 0; i < 400; i++) begin
            @(negedge clk);
            cnt_tick = 1'($urandom_range(0, 1));
            rd_addr  = 3'($urandom_range(0, 7));
            if ($urandom_range(0, 15) == 0) begin
                wr_en = 1'b1; wr_addr = 3'd4;
                wr_data = 16'($urandom_range(10, 20));
            end else begin
                wr_en = 1'b0;
            end
        end
        @(negedge clk);
        wr_en = 1'b0; cnt_tick = 1'b0;
        idle(3);

        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end
endmodule